// File: doc/BRIEF.md
# Serial Bus Slave Condition Framer

This block is the receive front end of a two-wire serial slave that follows SMBus and I2C conventions. It oversamples the clock line and the data line on a fast system clock and brings both into that clock domain through synchronizer chains. On the synchronized values it finds bus conditions. A falling data line while the clock is high opens a transfer. A rising data line while the clock is high closes one.

Inside a transfer it collects 8-bit words and pulses a strobe with each completed word. The strobe also tells whether the word was the first one after an opening condition. The block answers every word with an acknowledge on the ninth clock by enabling a low drive on the data line. For the first word, an external address comparator decides whether that acknowledge is given. If the comparator refuses the first word, the block stays silent until the next opening or closing condition.

Top module: `smb_frame_rx`

## Requirements
- R1: While reset is high and after it is released, bus_busy, sda_oe, rx_valid, start_pulse and stop_pulse are all 0.
- R2: A falling data line while the clock line is high (START) produces a one-cycle start_pulse and sets bus_busy to 1.
- R3: A rising data line while the clock line is high (STOP) produces a one-cycle stop_pulse and clears bus_busy to 0.
- R4: Data bits are taken on rising clock edges, most significant bit first. After the eighth bit, rx_valid pulses for one cycle with the word on rx_data. rx_first is 1 for the first word after a START or repeated START and 0 for later words.
- R5: The first word is acknowledged only if addr_match is 1 in the rx_valid cycle. Later words are always acknowledged. An acknowledge holds sda_oe at 1 from the falling clock edge after bit 8 to the falling edge of the ninth clock, so the data line reads 0 while the ninth clock is high.
- R6: If the first word is refused, sda_oe stays 0 and no rx_valid is produced until the next START or STOP.
- R7: A STOP in the middle of a word abandons the partial word. No rx_valid follows, and the next transfer starts from bit 0.
- R8: A STOP that falls in the same clock-high interval as a START is ignored. There is no stop_pulse, bus_busy stays 1, and the following word is received as a first word.
- R9: A repeated START, whether after an acknowledge or in the middle of a word, gives a start_pulse, keeps bus_busy at 1, restarts the bit count and marks the next word as first.
- R10: sda_oe never changes while the clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired value) |
| addr_match | input | 1 | 1 when rx_data holds this slave's address; sampled in the rx_valid cycle |
| sda_oe | output | 1 | 1 enables the low drive on the data line |
| rx_valid | output | 1 | One-cycle strobe for a completed word |
| rx_data | output | WORD_BITS (8) | Received word |
| rx_first | output | 1 | Word is the first after a START |
| bus_busy | output | 1 | A transfer is open |
| start_pulse | output | 1 | One-cycle pulse for START or repeated START |
| stop_pulse | output | 1 | One-cycle pulse for an accepted STOP |

## Verification
Two functions can act inside one clock-high interval of the bus: START detection, and the filter that must reject a STOP arriving before the clock falls again. The bench provokes this by lowering and then raising the data line within one clock-high phase from idle. It expects exactly one start event and no stop event in the scoreboard, and bus_busy is still 1 afterwards. The next word must then come out flagged as first and be acknowledged, which shows that the rejected STOP left the framing untouched.

// File: rtl/smb_frame_pkg.sv
package smb_frame_pkg;

  typedef enum logic [2:0] {
    FR_IDLE    = 3'd0,
    FR_RECV    = 3'd1,
    FR_DECIDE  = 3'd2,
    FR_ACKWAIT = 3'd3,
    FR_ACKDRV  = 3'd4,
    FR_IGNORE  = 3'd5
  } fr_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;
  logic raw_start, raw_stop;
  logic start_guard;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign raw_start = scl_s & scl_q & sda_q & ~sda_s;
  assign raw_stop  = scl_s & scl_q & ~sda_q & sda_s;

  // Guard is armed by a START and cleared only by the next falling clock edge.
  always_ff @(posedge clk) begin
    if (rst)            start_guard <= 1'b0;
    else if (raw_start) start_guard <= 1'b1;
    else if (scl_fall)  start_guard <= 1'b0;
  end

  assign start_ev = raw_start;
  assign stop_ev  = raw_stop & ~start_guard;

  // R8: no STOP is accepted in the cycle right after a START
  a_r8_no_stop_after_start: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !stop_ev);

endmodule

// File: rtl/smb_byte_ctrl.sv
module smb_byte_ctrl
  import smb_frame_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic                 sda_s,
  input  logic                 addr_match,
  output logic                 sda_oe,
  output logic                 rx_valid,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 rx_first,
  output logic                 bus_busy,
  output logic                 start_pulse,
  output logic                 stop_pulse
);

  localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  fr_state_e            state;
  logic [CNT_W-1:0]     bit_cnt;
  logic [WORD_BITS-1:0] shreg;
  logic [WORD_BITS-1:0] shreg_nxt;
  logic                 first_q;
  logic                 ack_go;

  assign shreg_nxt = {shreg[WORD_BITS-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= FR_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      first_q     <= 1'b0;
      ack_go      <= 1'b0;
      sda_oe      <= 1'b0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      rx_first    <= 1'b0;
      bus_busy    <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      if (start_ev) begin
        state       <= FR_RECV;
        bit_cnt     <= '0;
        first_q     <= 1'b1;
        sda_oe      <= 1'b0;
        bus_busy    <= 1'b1;
        start_pulse <= 1'b1;
      end else if (stop_ev) begin
        state      <= FR_IDLE;
        bit_cnt    <= '0;
        sda_oe     <= 1'b0;
        bus_busy   <= 1'b0;
        stop_pulse <= 1'b1;
      end else begin
        case (state)
          FR_RECV: begin
            if (scl_rise) begin
              shreg <= shreg_nxt;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt  <= '0;
                rx_data  <= shreg_nxt;
                rx_first <= first_q;
                rx_valid <= 1'b1;
                state    <= FR_DECIDE;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          FR_DECIDE: begin
            ack_go <= first_q ? addr_match : 1'b1;
            state  <= FR_ACKWAIT;
          end
          FR_ACKWAIT: begin
            if (scl_fall) begin
              if (ack_go) begin
                sda_oe <= 1'b1;
                state  <= FR_ACKDRV;
              end else begin
                state <= FR_IGNORE;
              end
            end
          end
          FR_ACKDRV: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              first_q <= 1'b0;
              state   <= FR_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: START opens the bus
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (bus_busy && start_pulse));

  // R3: accepted STOP closes the bus
  a_r3_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && !start_ev) |=> (!bus_busy && stop_pulse));

  // R4: words only appear inside an open transfer
  a_r4_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> bus_busy);

  // R5: acknowledge drive only inside an open transfer
  a_r5_oe_in_busy: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> bus_busy);

  // R6: a refused address never drives the line
  a_r6_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == FR_IGNORE) |-> (!sda_oe && !rx_valid));

endmodule

// File: rtl/smb_frame_rx.sv
module smb_frame_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 addr_match,
  output logic                 sda_oe,
  output logic                 rx_valid,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 rx_first,
  output logic                 bus_busy,
  output logic                 start_pulse,
  output logic                 stop_pulse
);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s)
  );

  smb_cond_det u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_byte_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .sda_s       (sda_s),
    .addr_match  (addr_match),
    .sda_oe      (sda_oe),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_first    (rx_first),
    .bus_busy    (bus_busy),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
  );

  // R10: drive enable holds still across a clock-high interval
  a_r10_oe_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R1: no pulses right out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!rx_valid && !start_pulse && !stop_pulse && !sda_oe));

endmodule

// File: tb/smb_frame_rx_tb_top.sv
module smb_frame_rx_tb_top;

  localparam int Q = 10;
  localparam logic [6:0] MY_ADDR = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic addr_match;
  logic sda_oe, rx_valid, rx_first, bus_busy, start_pulse, stop_pulse;
  logic [7:0] rx_data;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  int         q_kind[$];
  logic [7:0] q_data[$];
  bit         q_first[$];
  string      q_req[$];

  always #4 clk = ~clk;

  assign sda_line   = sda_m & ~sda_oe;
  assign addr_match = (rx_data[7:1] == MY_ADDR);

  smb_frame_rx dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .addr_match(addr_match), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .bus_busy(bus_busy),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [7:0] d, input bit f, input string req);
    q_kind.push_back(kind);
    q_data.push_back(d);
    q_first.push_back(f);
    q_req.push_back(req);
  endtask

  task automatic pop_cmp(input int kind, input logic [7:0] d, input bit f);
    vectors++;
    if (q_kind.size() == 0) begin
      fails++;
      $display("FAIL R6/R7/R8 unexpected output kind=%0d actual=%0h expected=none", kind, d);
    end else begin
      int ek;
      logic [7:0] ed;
      bit ef;
      string er;
      ek = q_kind.pop_front();
      ed = q_data.pop_front();
      ef = q_first.pop_front();
      er = q_req.pop_front();
      if (ek != kind || (kind == 0 && (ed !== d || ef !== f))) begin
        fails++;
        $display("FAIL %s actual kind=%0d data=%0h first=%0b expected kind=%0d data=%0h first=%0b",
                 er, kind, d, f, ek, ed, ef);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (start_pulse) pop_cmp(1, 8'h00, 1'b0);
      if (stop_pulse)  pop_cmp(2, 8'h00, 1'b0);
      if (rx_valid)    pop_cmp(0, rx_data, rx_first);
    end
  end

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_rep_start;
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b1; qwait;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait;
    scl_m = 1'b1; qwait; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
    logic oe_first;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    chk({req, " ack line"}, {31'd0, sda_line}, {31'd0, ~exp_ack});
    chk({req, " ack drive"}, {31'd0, sda_oe}, {31'd0, exp_ack});
    oe_first = sda_oe;
    qwait;
    chk("R10 oe stable in high phase", {31'd0, sda_oe}, {31'd0, oe_first});
    scl_m = 1'b0; qwait;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    chk("R1 busy in reset", {31'd0, bus_busy}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 busy", {31'd0, bus_busy}, 32'd0);
    chk("R1 oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 valid", {31'd0, rx_valid}, 32'd0);

    // plain write: address then two data words
    push(1, 0, 0, "R2 start");
    bus_start;
    chk("R2 busy after start", {31'd0, bus_busy}, 32'd1);
    push(0, 8'h58, 1, "R4 address word");
    send_byte(8'h58, 1, "R5 address");
    push(0, 8'hA5, 0, "R4 data word");
    send_byte(8'hA5, 1, "R5 data");
    push(0, 8'h3C, 0, "R4 data word 2");
    send_byte(8'h3C, 1, "R5 data 2");
    push(2, 0, 0, "R3 stop");
    bus_stop;
    chk("R3 busy after stop", {31'd0, bus_busy}, 32'd0);

    // refused address
    push(1, 0, 0, "R2 start");
    bus_start;
    push(0, 8'h20, 1, "R6 foreign address word");
    send_byte(8'h20, 0, "R6 nack");
    send_byte(8'hFF, 0, "R6 ignored word");
    chk("R6 oe idle", {31'd0, sda_oe}, 32'd0);
    push(2, 0, 0, "R3 stop");
    bus_stop;

    // stop in the middle of a word
    push(1, 0, 0, "R2 start");
    bus_start;
    push(0, 8'h58, 1, "R7 address");
    send_byte(8'h58, 1, "R5 address");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    push(2, 0, 0, "R7 early stop");
    bus_stop;
    chk("R7 busy after early stop", {31'd0, bus_busy}, 32'd0);
    push(1, 0, 0, "R7 restart");
    bus_start;
    push(0, 8'h58, 1, "R7 clean address");
    send_byte(8'h58, 1, "R7 address ack");
    push(0, 8'h81, 0, "R7 clean data");
    send_byte(8'h81, 1, "R7 data ack");
    push(2, 0, 0, "R3 stop");
    bus_stop;

    // repeated start after ack and mid-word
    push(1, 0, 0, "R2 start");
    bus_start;
    push(0, 8'h58, 1, "R4 address");
    send_byte(8'h58, 1, "R5 address");
    push(1, 0, 0, "R9 repeated start");
    bus_rep_start;
    chk("R9 busy kept", {31'd0, bus_busy}, 32'd1);
    push(0, 8'h59, 1, "R9 first after repeat");
    send_byte(8'h59, 1, "R9 address ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    push(1, 0, 0, "R9 repeated start mid-word");
    bus_rep_start;
    push(0, 8'h59, 1, "R9 count restarted");
    send_byte(8'h59, 1, "R9 address ack 2");
    push(0, 8'h77, 0, "R9 data");
    send_byte(8'h77, 1, "R9 data ack");
    push(2, 0, 0, "R3 stop");
    bus_stop;

    // START and STOP inside one clock-high interval
    qwait;
    push(1, 0, 0, "R8 start");
    sda_m = 1'b0; qwait;
    sda_m = 1'b1; qwait;
    scl_m = 1'b0; qwait;
    chk("R8 busy kept", {31'd0, bus_busy}, 32'd1);
    push(0, 8'h58, 1, "R8 first word");
    send_byte(8'h58, 1, "R8 address ack");
    push(2, 0, 0, "R3 stop");
    bus_stop;

    repeat (50) @(negedge clk);
    done = 1'b1;
    while (q_kind.size() > 0) begin
      string er;
      int ek;
      er = q_req.pop_front();
      ek = q_kind.pop_front();
      void'(q_data.pop_front());
      void'(q_first.pop_front());
      vectors++;
      fails++;
      $display("FAIL %s actual=missing expected kind=%0d", er, ek);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule